// File: doc/BRIEF.md
# Cluster Task Dispatcher with Neighbour Lending

This block is the local scheduler of one processing cluster. A global scheduler hands it task commands over a valid/ready channel. Each command carries a kind bit and an 8-bit task ID, and the block buffers it in a 16-entry FIFO. The cluster owns one vector worker and eight scalar workers. The block looks at the head of the FIFO once per service slot, and slots are twenty cycles apart. It starts the head task on a free worker of the matching kind with a one-cycle start strobe and the task ID.

When no local scalar worker is free, a scalar head task is offered to the two adjacent clusters, the left one first. The block also answers the same offer arriving from those neighbours. It does this only with scalar workers that its own dispatch leaves free in that cycle. Workers report completion with a one-cycle done pulse. The block returns each completion to the global scheduler as a worker index together with the ID that the worker was started with.

Top module: `task_dispatch_unit`

## Requirements
- R1: After reset, the FIFO is empty and `req_ready_o` is high. No start strobe, lend request, neighbour acknowledge or completion is raised, and every worker is free.
- R2: A command is accepted in a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low exactly while 16 commands are held. A sender that holds its command through a full period loses nothing, and commands leave in arrival order.
- R3: A dispatch attempt on the head command occurs when the FIFO is non-empty and at least 19 cycles have passed since the last attempt or since reset. The slot counter restarts after every attempt, whether it succeeds or not, and a head command that fails stays at the head for the next slot.
- R4: `req_kind_i` = 0 marks a vector task. Such a task starts only on the vector worker (`vec_start_o` with `vec_id_o`), and only when that worker is free.
- R5: `req_kind_i` = 1 marks a scalar task. It starts on the lowest-index free local scalar worker: bit i of `sc_start_o` pulses for one cycle, and the ID appears on `sc_id_o[8*i+7:8*i]`.
- R6: A scalar head task with no free local scalar worker raises `lend_req_o[0]` with the ID on `lend_id_o`. `lend_req_o[1]` is raised in the same cycle unless `lend_ack_i[0]` is high. An acknowledged request removes the command. If neither acknowledge comes, the command stays queued.
- R7: `nb_req_i[n]` (ID on `nb_id_i[8*n+7:8*n]`) is acknowledged on `nb_ack_o[n]` in the same cycle only if a scalar worker is still free after local dispatch, neighbour 0 being served before neighbour 1. The accepted task starts on the lowest such worker. Otherwise the request is refused.
- R8: A done pulse on a busy worker produces one completion, with `cmpl_worker_o` holding the index (0 to 7 for scalar workers, 8 for the vector worker) and `cmpl_id_o` holding its ID. Pending completions are reported one per cycle, lowest index first. A done pulse on a free worker is ignored.
- R9: A worker is not free from its start until the cycle after its completion has been reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command offered |
| req_ready_o | output | 1 | FIFO has room |
| req_kind_i | input | 1 | 0 vector task, 1 scalar task |
| req_id_i | input | 8 | Task ID |
| vec_start_o | output | 1 | Start strobe of the vector worker |
| vec_id_o | output | 8 | ID for the vector worker |
| vec_done_i | input | 1 | Vector worker finished |
| sc_start_o | output | 8 | Start strobes of scalar workers |
| sc_id_o | output | 64 | Per-worker ID for scalar workers |
| sc_done_i | input | 8 | Scalar workers finished |
| lend_req_o | output | 2 | Offer head task to neighbour 0 (left) / 1 (right) |
| lend_id_o | output | 8 | ID of the offered task |
| lend_ack_i | input | 2 | Neighbour took the offered task |
| nb_req_i | input | 2 | Neighbour offers a task |
| nb_id_i | input | 16 | IDs of neighbour offers |
| nb_ack_o | output | 2 | Neighbour offer accepted |
| cmpl_valid_o | output | 1 | Completion reported |
| cmpl_worker_o | output | 4 | Index of the finished worker |
| cmpl_id_o | output | 8 | ID of the finished task |

## Verification
The bench builds the block with its default parameters: a 16-deep FIFO, a 20-cycle slot and eight scalar workers, with two neighbours. With these values a short burst of scalar commands fills the FIFO while neighbours refuse every offer, so the full condition and the held sender are both exercised. Eight long-running tasks saturate every local scalar worker, which brings lending, refused lending and refused neighbour offers into play. A single pulse on all done inputs then drains eight completions through the lowest-index ordering.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
  typedef enum logic {
    KIND_VEC = 1'b0,
    KIND_SCL = 1'b1
  } task_kind_e;
endpackage

// File: rtl/tdu_cmd_fifo.sv
module tdu_cmd_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
endmodule

// File: rtl/tdu_slot_timer.sv
module tdu_slot_timer #(
  parameter int PERIOD = 20,
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  output logic attempt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign attempt_o = pending_i && (cnt_q == CNT_W'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (attempt_o)                    cnt_q <= '0;
    else if (cnt_q != CNT_W'(PERIOD - 1))  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/tdu_worker_track.sv
module tdu_worker_track #(
  parameter int NW    = 9,
  parameter int ID_W  = 8,
  localparam int IX_W = $clog2(NW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NW-1:0]    start_i,
  input  logic [NW*ID_W-1:0] sid_i,
  input  logic [NW-1:0]    done_i,
  output logic [NW-1:0]    avail_o,
  output logic             cmpl_valid_o,
  output logic [IX_W-1:0]  cmpl_idx_o,
  output logic [ID_W-1:0]  cmpl_id_o
);
  localparam logic [NW-1:0] ONE = NW'(1);

  logic [NW-1:0]   busy_q, pend_q, rep;
  logic [ID_W-1:0] id_q [NW];

  assign avail_o      = ~busy_q & ~pend_q;
  assign rep          = pend_q & (~pend_q + ONE);
  assign cmpl_valid_o = |pend_q;

  always_comb begin
    cmpl_idx_o = '0;
    cmpl_id_o  = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (pend_q[w]) begin
        cmpl_idx_o = IX_W'(w);
        cmpl_id_o  = id_q[w];
      end
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_wk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[w] <= 1'b0;
        pend_q[w] <= 1'b0;
        id_q[w]   <= '0;
      end else begin
        if (start_i[w]) begin
          busy_q[w] <= 1'b1;
          id_q[w]   <= sid_i[w*ID_W +: ID_W];
        end else if (done_i[w] && busy_q[w]) begin
          busy_q[w] <= 1'b0;
          pend_q[w] <= 1'b1;
        end
        if (rep[w]) pend_q[w] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/task_dispatch_unit.sv
module task_dispatch_unit
  import tdu_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int PERIOD     = 20,
  parameter int NUM_SCALAR = 8,
  parameter int NUM_NEIGH  = 2,
  parameter int ID_W       = 8,
  localparam int NW        = NUM_SCALAR + 1,
  localparam int IX_W      = $clog2(NW),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_kind_i,
  input  logic [ID_W-1:0]           req_id_i,
  output logic                      vec_start_o,
  output logic [ID_W-1:0]           vec_id_o,
  input  logic                      vec_done_i,
  output logic [NUM_SCALAR-1:0]     sc_start_o,
  output logic [NUM_SCALAR*ID_W-1:0] sc_id_o,
  input  logic [NUM_SCALAR-1:0]     sc_done_i,
  output logic [NUM_NEIGH-1:0]      lend_req_o,
  output logic [ID_W-1:0]           lend_id_o,
  input  logic [NUM_NEIGH-1:0]      lend_ack_i,
  input  logic [NUM_NEIGH-1:0]      nb_req_i,
  input  logic [NUM_NEIGH*ID_W-1:0] nb_id_i,
  output logic [NUM_NEIGH-1:0]      nb_ack_o,
  output logic                      cmpl_valid_o,
  output logic [IX_W-1:0]           cmpl_worker_o,
  output logic [ID_W-1:0]           cmpl_id_o
);
  localparam logic [NUM_SCALAR-1:0] SC_ONE = NUM_SCALAR'(1);

  logic [ID_W:0]     head;
  logic              empty, full, attempt, pop, lent, want_lend;
  logic [CW-1:0]     fifo_cnt;
  logic [NW-1:0]     avail;
  logic [NUM_SCALAR-1:0] sc_avail, loc_mask, rem_left;
  logic              vec_avail, head_scl;
  logic [NUM_NEIGH-1:0][NUM_SCALAR-1:0] nb_mask;

  assign req_ready_o = !full;

  tdu_cmd_fifo #(.DEPTH(DEPTH), .W(ID_W + 1)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (req_valid_i && !full),
    .data_i ({req_kind_i, req_id_i}),
    .pop_i  (pop),
    .data_o (head),
    .empty_o(empty),
    .full_o (full),
    .count_o(fifo_cnt)
  );

  tdu_slot_timer #(.PERIOD(PERIOD)) u_timer (
    .clk_i, .rst_ni,
    .pending_i(!empty),
    .attempt_o(attempt)
  );

  assign sc_avail  = avail[NUM_SCALAR-1:0];
  assign vec_avail = avail[NUM_SCALAR];
  assign head_scl  = (task_kind_e'(head[ID_W]) == KIND_SCL);

  // local dispatch of the head command
  assign vec_start_o = attempt && !head_scl && vec_avail;
  assign vec_id_o    = head[ID_W-1:0];
  assign loc_mask    = (attempt && head_scl) ? (sc_avail & (~sc_avail + SC_ONE)) : '0;
  assign want_lend   = attempt && head_scl && (sc_avail == '0);
  assign lend_id_o   = head[ID_W-1:0];

  // offer to neighbours in fixed order
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int n = 0; n < NUM_NEIGH; n++) begin
      lend_req_o[n] = want_lend && !taken;
      taken         = taken | lend_ack_i[n];
    end
    lent = want_lend && taken;
  end

  assign pop = vec_start_o || (loc_mask != '0) || lent;

  // neighbour offers use what local dispatch leaves
  always_comb begin
    logic [NUM_SCALAR-1:0] rem, pick;
    rem = sc_avail & ~loc_mask;
    for (int n = 0; n < NUM_NEIGH; n++) begin
      pick        = rem & (~rem + SC_ONE);
      nb_ack_o[n] = nb_req_i[n] && (rem != '0);
      nb_mask[n]  = nb_ack_o[n] ? pick : '0;
      rem         = rem & ~nb_mask[n];
    end
    rem_left = rem;
  end

  for (genvar s = 0; s < NUM_SCALAR; s++) begin : g_sc
    always_comb begin
      sc_start_o[s]              = loc_mask[s];
      sc_id_o[s*ID_W +: ID_W]    = loc_mask[s] ? head[ID_W-1:0] : '0;
      for (int n = 0; n < NUM_NEIGH; n++) begin
        if (nb_mask[n][s]) begin
          sc_start_o[s]           = 1'b1;
          sc_id_o[s*ID_W +: ID_W] = nb_id_i[n*ID_W +: ID_W];
        end
      end
    end
  end

  tdu_worker_track #(.NW(NW), .ID_W(ID_W)) u_track (
    .clk_i, .rst_ni,
    .start_i     ({vec_start_o, sc_start_o}),
    .sid_i       ({vec_id_o, sc_id_o}),
    .done_i      ({vec_done_i, sc_done_i}),
    .avail_o     (avail),
    .cmpl_valid_o(cmpl_valid_o),
    .cmpl_idx_o  (cmpl_worker_o),
    .cmpl_id_o   (cmpl_id_o)
  );
endmodule

// File: rtl/tdu_checker.sv
module tdu_checker #(
  parameter int NS     = 8,
  parameter int NB     = 2,
  parameter int DEPTH  = 16,
  parameter int PERIOD = 20,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NS-1:0] sc_start_i,
  input logic [NS-1:0] sc_avail_i,
  input logic          vec_start_i,
  input logic          vec_avail_i,
  input logic [NB-1:0] nb_req_i,
  input logic [NB-1:0] nb_ack_i,
  input logic [CW-1:0] fifo_cnt_i,
  input logic          pop_i
);
  int gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= 0;
    else if (pop_i)       gap_q <= 0;
    else if (gap_q < PERIOD) gap_q <= gap_q + 1;
  end

  AST_SC_START_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_start_i & ~sc_avail_i) == '0);  // R9
  AST_VEC_START_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_start_i |-> vec_avail_i);  // R4
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nb_ack_i & ~nb_req_i) == '0);  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CW'(DEPTH));  // R2
  AST_SLOT_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> gap_q >= PERIOD - 1);  // R3
endmodule

bind task_dispatch_unit tdu_checker #(
  .NS(NUM_SCALAR), .NB(NUM_NEIGH), .DEPTH(DEPTH), .PERIOD(PERIOD)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sc_start_i (sc_start_o),
  .sc_avail_i (sc_avail),
  .vec_start_i(vec_start_o),
  .vec_avail_i(vec_avail),
  .nb_req_i   (nb_req_i),
  .nb_ack_i   (nb_ack_o),
  .fifo_cnt_i (fifo_cnt),
  .pop_i      (pop)
);

// File: tb/task_dispatch_unit_tb_top.sv
`timescale 1ns/1ps
module task_dispatch_unit_tb_top;
  localparam int DEPTH = 16, PERIOD = 20, NS = 8, NB = 2, ID_W = 8;
  localparam int NW = NS + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_kind = 1'b0;
  logic [ID_W-1:0] req_id = '0;
  logic req_ready_o, vec_start_o, cmpl_valid_o;
  logic [ID_W-1:0] vec_id_o, lend_id_o, cmpl_id_o;
  logic [NS-1:0] sc_start_o;
  logic [NS*ID_W-1:0] sc_id_o;
  logic [NB-1:0] lend_req_o, nb_ack_o;
  logic [NB-1:0] lend_ack = '0, nb_req = '0;
  logic [NB*ID_W-1:0] nb_id = '0;
  logic [3:0] cmpl_worker_o;
  logic [NW-1:0] auto_done = '0, extra_done = '0, done_all;
  assign done_all = auto_done | extra_done;

  task_dispatch_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_kind_i(req_kind), .req_id_i(req_id),
    .vec_start_o(vec_start_o), .vec_id_o(vec_id_o), .vec_done_i(done_all[NS]),
    .sc_start_o(sc_start_o), .sc_id_o(sc_id_o), .sc_done_i(done_all[NS-1:0]),
    .lend_req_o(lend_req_o), .lend_id_o(lend_id_o), .lend_ack_i(lend_ack),
    .nb_req_i(nb_req), .nb_id_i(nb_id), .nb_ack_o(nb_ack_o),
    .cmpl_valid_o(cmpl_valid_o), .cmpl_worker_o(cmpl_worker_o), .cmpl_id_o(cmpl_id_o)
  );

  int total = 0, bad = 0;
  int saw_full = 0, saw_lend2 = 0, saw_lent = 0, saw_nback = 0, saw_nbref = 0;
  int saw_cmpl = 0, saw_vec = 0, saw_sc = 0, quiet_cmpl = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [ID_W:0] mq[$];
  bit mbusy[NW], mpend[NW];
  logic [ID_W-1:0] mid[NW];
  int mcnt = 0, lat = 30;
  int tmr[NW];
  bit e_ready, e_push, e_pop, e_cv;
  bit e_start[NW];
  logic [ID_W-1:0] e_sid[NW], e_cid;
  bit [NB-1:0] e_lend, e_ack;
  int e_cw;

  initial for (int w = 0; w < NW; w++) begin mbusy[w] = 0; mpend[w] = 0; mid[w] = '0; tmr[w] = 0; end

  always @(negedge clk) begin
    bit att, taken, av[NW];
    logic [ID_W:0] hd;
    e_ready = mq.size() < DEPTH;
    e_push = req_valid && e_ready;
    att = (mcnt == PERIOD - 1) && mq.size() > 0;
    e_pop = 0; e_lend = '0; e_ack = '0; e_cv = 0; e_cw = 0; e_cid = '0;
    for (int w = 0; w < NW; w++) begin av[w] = !mbusy[w] && !mpend[w]; e_start[w] = 0; e_sid[w] = '0; end
    if (att) begin
      hd = mq[0];
      if (!hd[ID_W]) begin
        if (av[NS]) begin e_start[NS] = 1; e_sid[NS] = hd[ID_W-1:0]; e_pop = 1; end
      end else begin
        for (int w = 0; w < NS; w++)
          if (av[w] && !e_pop) begin e_start[w] = 1; e_sid[w] = hd[ID_W-1:0]; e_pop = 1; end
        if (!e_pop) begin
          taken = 0;
          for (int n = 0; n < NB; n++) begin
            e_lend[n] = !taken;
            if (lend_ack[n]) taken = 1;
          end
          e_pop = taken;
        end
      end
    end
    for (int n = 0; n < NB; n++)
      if (nb_req[n])
        for (int w = 0; w < NS; w++)
          if (av[w] && !e_start[w] && !e_ack[n]) begin
            e_ack[n] = 1; e_start[w] = 1; e_sid[w] = nb_id[n*ID_W +: ID_W];
          end
    for (int w = NW - 1; w >= 0; w--)
      if (mpend[w]) begin e_cv = 1; e_cw = w; e_cid = mid[w]; end

    if (rst_ni) begin
      chk(req_ready_o == e_ready, "R2 ready", req_ready_o, e_ready);
      chk(vec_start_o == e_start[NS], "R3 R4 vec_start", vec_start_o, e_start[NS]);
      if (e_start[NS]) chk(vec_id_o == e_sid[NS], "R4 vec_id", vec_id_o, e_sid[NS]);
      for (int s = 0; s < NS; s++) begin
        chk(sc_start_o[s] == e_start[s], "R3 R5 sc_start", sc_start_o[s], e_start[s]);
        if (e_start[s]) chk(sc_id_o[s*ID_W +: ID_W] == e_sid[s], "R5 sc_id", sc_id_o[s*ID_W +: ID_W], e_sid[s]);
        if (sc_start_o[s]) chk(!mbusy[s] && !mpend[s], "R9 start on free", s, 0);
      end
      chk(lend_req_o == e_lend, "R6 lend_req", lend_req_o, e_lend);
      if (e_lend != '0) chk(lend_id_o == mq[0][ID_W-1:0], "R6 lend_id", lend_id_o, mq[0][ID_W-1:0]);
      chk(nb_ack_o == e_ack, "R7 nb_ack", nb_ack_o, e_ack);
      chk(cmpl_valid_o == e_cv, "R8 cmpl_valid", cmpl_valid_o, e_cv);
      if (e_cv) begin
        chk(cmpl_worker_o == e_cw, "R8 cmpl_worker", cmpl_worker_o, e_cw);
        chk(cmpl_id_o == e_cid, "R8 cmpl_id", cmpl_id_o, e_cid);
      end
      if (!req_ready_o) saw_full++;
      if (lend_req_o == 2'b11) saw_lend2++;
      if ((lend_req_o & lend_ack) != '0) saw_lent++;
      if (nb_ack_o != '0) saw_nback++;
      if ((nb_req & ~nb_ack_o) != '0) saw_nbref++;
      if (cmpl_valid_o) saw_cmpl++;
      if (vec_start_o) saw_vec++;
      if (sc_start_o != '0) saw_sc++;
    end
  end

  always @(posedge clk) begin
    if (!rst_ni) begin
      mq.delete(); mcnt = 0;
      for (int w = 0; w < NW; w++) begin mbusy[w] = 0; mpend[w] = 0; tmr[w] = 0; end
    end else begin
      if (e_push) mq.push_back({req_kind, req_id});
      if (e_pop) void'(mq.pop_front());
      if ((mcnt == PERIOD - 1) && mq.size() + (e_pop ? 1 : 0) - (e_push ? 1 : 0) > 0) mcnt = 0;
      else if (mcnt < PERIOD - 1) mcnt++;
      if (e_cv) mpend[e_cw] = 0;
      for (int w = 0; w < NW; w++) begin
        if (e_start[w]) begin mbusy[w] = 1; mid[w] = e_sid[w]; tmr[w] = lat; end
        else if (done_all[w] && mbusy[w]) begin mbusy[w] = 0; mpend[w] = 1; end
      end
    end
    #1;
    for (int w = 0; w < NW; w++) begin
      auto_done[w] = 1'b0;
      if (tmr[w] > 0) begin tmr[w]--; if (tmr[w] == 0) auto_done[w] = 1'b1; end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic send(input logic k, input logic [ID_W-1:0] id);
    bit r;
    req_valid = 1; req_kind = k; req_id = id;
    forever begin
      @(negedge clk); r = req_ready_o;
      @(posedge clk); #2;
      if (r) break;
    end
    req_valid = 0;
  endtask

  bit finished = 0;
  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3); rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready_o && !vec_start_o && sc_start_o == '0 && lend_req_o == '0 &&
        nb_ack_o == '0 && !cmpl_valid_o, "R1 reset state", 0, 0);
    step(1);
    // mixed vector/scalar traffic
    lat = 30;
    send(0, 8'h11); send(1, 8'h21); send(1, 8'h22); send(0, 8'h12); send(1, 8'h23);
    step(250);
    // saturate scalar workers
    lat = 0;
    for (int i = 0; i < NS; i++) send(1, 8'h30 + 8'(i));
    send(1, 8'h40);
    step(NS * PERIOD + 60);
    nb_req = 2'b11; nb_id = {8'h91, 8'h90}; step(3); nb_req = '0;
    lend_ack = 2'b10; step(PERIOD + 5);
    lend_ack = 2'b11; send(1, 8'h41); step(PERIOD + 25);
    // fill the FIFO with neighbours refusing
    lend_ack = 2'b00;
    for (int i = 0; i < DEPTH; i++) send(1, 8'hA0 + 8'(i));
    fork send(1, 8'hB0); join_none
    step(60);
    lend_ack = 2'b01;
    step((DEPTH + 2) * PERIOD + 40);
    lend_ack = 2'b00;
    // release all scalar workers at once
    extra_done = '1; step(1); extra_done = '0;
    step(20);
    // done on free workers is ignored
    extra_done = '1; step(1); extra_done = '0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (cmpl_valid_o) quiet_cmpl++; end
    chk(quiet_cmpl == 0, "R8 done on free ignored", quiet_cmpl, 0);
    // neighbour offers with local traffic
    lat = 25;
    fork begin send(1, 8'hC0); send(1, 8'hC1); send(0, 8'hC2); end join_none
    for (int i = 0; i < 60; i++) begin
      nb_req = 2'b11; nb_id = {8'hE0 + 8'(i), 8'hD0 + 8'(i)}; step(1);
    end
    nb_req = '0;
    step(300);
    chk(saw_full > 0, "R2 full reached", saw_full, 1);
    chk(saw_lend2 > 0, "R6 both neighbours asked", saw_lend2, 1);
    chk(saw_lent > 0, "R6 task lent", saw_lent, 1);
    chk(saw_nback > 0, "R7 offer accepted", saw_nback, 1);
    chk(saw_nbref > 0, "R7 offer refused", saw_nbref, 1);
    chk(saw_cmpl > 0, "R8 completions seen", saw_cmpl, 1);
    chk(saw_vec > 0, "R4 vector starts seen", saw_vec, 1);
    chk(saw_sc > 0, "R5 scalar starts seen", saw_sc, 1);
    chk(mq.size() == 0, "R3 queue drained", mq.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule